// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. Each cycle it receives two operands, a three-bit condition code, a sign-select bit and a valid strobe. It compares the operands for equality and for order, and it returns a taken flag and a flag that marks a reserved condition code. Both flags are forced low whenever the strobe is low.

The ordered tests treat the operands as unsigned or as two's-complement values, depending on the sign-select bit. Internally the comparison is built from parallel slice comparators that are merged from the most significant slice down. Target address arithmetic and any pipeline flush belong to the surrounding core. A parameter chooses whether the result leaves through a register stage, one clock after the inputs, or leaves directly from the logic.

Top module: `branch_decider`

## Requirements
- R1: Condition code 3'b000 takes the branch exactly when the two operands are equal, whatever the sign-select bit is.
- R2: Condition code 3'b100 takes the branch exactly when the two operands differ, whatever the sign-select bit is.
- R3: Condition code 3'b001 takes the branch when lhs > rhs, and code 3'b010 takes it when lhs >= rhs.
- R4: Condition code 3'b101 takes the branch when lhs < rhs, and code 3'b110 takes it when lhs <= rhs.
- R5: With sign_sel_i = 1 the ordered codes (001, 010, 101, 110) compare two's-complement values. With sign_sel_i = 0 they compare unsigned values.
- R6: Codes 3'b011 and 3'b111 are reserved. A valid reserved code drives taken_o low and rsvd_o high. Every other code drives rsvd_o low.
- R7: When vld_i is low, taken_o and rsvd_o are both low.
- R8: With OUT_REG = 1 (the default), the outputs show the result for the inputs sampled at a rising clock edge, from that edge until the next one.
- R9: While rst_n is low at a rising edge, that edge clears both registered outputs, even if vld_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Qualifies the inputs of this cycle |
| lhs_i | input | DATA_W | Left operand |
| rhs_i | input | DATA_W | Right operand |
| cond_i | input | 3 | Condition code |
| sign_sel_i | input | 1 | 1 selects signed ordered tests |
| taken_o | output | 1 | Branch taken |
| rsvd_o | output | 1 | Reserved condition code seen |

## Verification
The block holds no state beyond its single output stage. A fault in the slice merge or in the condition decode therefore shows on taken_o at the very edge after the offending operands are presented, and it shows no later than that. Faults in the merge appear only for particular operand pairs, such as a difference confined to a lower slice or a set top bit under signed mode. For this reason the stimulus deliberately moves differences across the slice boundaries and across the sign bit. A fault in the stage's reset or valid gating shows as a stray high flag on the cycle that follows a reset or idle cycle.

// File: rtl/brc_pkg.sv
// Package: shared condition-code type for the branch evaluator.
// Assumes a three-bit code. Bit 2 pairs each test with its counterpart.
package brc_pkg;

    typedef enum logic [2:0] {
        COND_EQ   = 3'b000,
        COND_GT   = 3'b001,
        COND_GE   = 3'b010,
        COND_RSVA = 3'b011,
        COND_NE   = 3'b100,
        COND_LT   = 3'b101,
        COND_LE   = 3'b110,
        COND_RSVB = 3'b111
    } cond_t;

    localparam int COND_W = 3;

endpackage

// File: rtl/brc_magcmp.sv
// Module: magnitude and equality comparator built from parallel slices.
// Signed order is obtained by inverting the top bit of both operands and
// then comparing unsigned. Equality does not depend on the sign mode.
// Assumes DATA_W is a multiple of SLICE_W.
module brc_magcmp #(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_i,
    output logic              eq_o,
    output logic              lt_o
);
    localparam int NSLICE = DATA_W / SLICE_W;

    logic [DATA_W-1:0] a_k;
    logic [DATA_W-1:0] b_k;
    logic [NSLICE-1:0] s_eq;
    logic [NSLICE-1:0] s_lt;

    // Bias the top bit so that signed order maps onto unsigned order.
    always_comb begin
        a_k = {a_i[DATA_W-1] ^ signed_i, a_i[DATA_W-2:0]};
        b_k = {b_i[DATA_W-1] ^ signed_i, b_i[DATA_W-2:0]};
    end

    // One equality and one less-than comparator per slice.
    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        always_comb begin
            s_eq[g] = a_k[g*SLICE_W +: SLICE_W] == b_k[g*SLICE_W +: SLICE_W];
            s_lt[g] = a_k[g*SLICE_W +: SLICE_W] <  b_k[g*SLICE_W +: SLICE_W];
        end
    end

    // Merge slices: the highest differing slice decides the order.
    always_comb begin
        logic upper_eq;
        upper_eq = 1'b1;
        lt_o     = 1'b0;
        for (int i = NSLICE - 1; i >= 0; i--) begin
            if (upper_eq && s_lt[i]) lt_o = 1'b1;
            upper_eq = upper_eq & s_eq[i];
        end
        eq_o = upper_eq;
    end

endmodule

// File: rtl/brc_cond_sel.sv
// Module: maps a condition code and the compare flags to a taken decision.
// Assumes eq and lt come from one comparator run on the same operands.
module brc_cond_sel
    import brc_pkg::*;
(
    input  cond_t cond_i,
    input  logic  eq_i,
    input  logic  lt_i,
    output logic  hit_o,
    output logic  rsvd_o
);
    logic gt;

    // Strictly greater is neither less nor equal.
    always_comb gt = ~lt_i & ~eq_i;

    // Pick the test named by the condition code.
    always_comb begin
        hit_o  = 1'b0;
        rsvd_o = 1'b0;
        case (cond_i)
            COND_EQ: hit_o = eq_i;
            COND_NE: hit_o = ~eq_i;
            COND_GT: hit_o = gt;
            COND_GE: hit_o = ~lt_i;
            COND_LT: hit_o = lt_i;
            COND_LE: hit_o = ~gt;
            default: rsvd_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/brc_out_stage.sv
// Module: gates the result with valid and optionally registers it.
// With OUT_REG = 1 the outputs change on the rising edge and a low rst_n
// clears them synchronously. With OUT_REG = 0 the path is combinational.
module brc_out_stage #(
    parameter bit OUT_REG = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic hit_i,
    input  logic rsvd_i,
    output logic taken_o,
    output logic rsvd_o
);
    logic taken_d;
    logic rsvd_d;

    // Qualify both flags with the valid strobe.
    always_comb begin
        taken_d = vld_i & hit_i & ~rsvd_i;
        rsvd_d  = vld_i & rsvd_i;
    end

    if (OUT_REG) begin : g_reg
        // Output register with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                taken_o <= 1'b0;
                rsvd_o  <= 1'b0;
            end else begin
                taken_o <= taken_d;
                rsvd_o  <= rsvd_d;
            end
        end
    end else begin : g_comb
        // Direct path, no storage.
        always_comb begin
            taken_o = taken_d;
            rsvd_o  = rsvd_d;
        end
    end

endmodule

// File: rtl/branch_decider.sv
// Module: top of the branch condition evaluator.
// Compares the operands, decodes the condition and presents qualified
// flags. Assumes DATA_W is a multiple of SLICE_W and at least 2.
module branch_decider
    import brc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    input  logic [2:0]        cond_i,
    input  logic              sign_sel_i,
    output logic              taken_o,
    output logic              rsvd_o
);
    logic  cmp_eq;
    logic  cmp_lt;
    logic  sel_hit;
    logic  sel_rsvd;
    cond_t cond;

    // Give the raw code its enumerated type.
    always_comb cond = cond_t'(cond_i);

    brc_magcmp #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_cmp (
        .a_i      (lhs_i),
        .b_i      (rhs_i),
        .signed_i (sign_sel_i),
        .eq_o     (cmp_eq),
        .lt_o     (cmp_lt)
    );

    brc_cond_sel u_sel (
        .cond_i (cond),
        .eq_i   (cmp_eq),
        .lt_i   (cmp_lt),
        .hit_o  (sel_hit),
        .rsvd_o (sel_rsvd)
    );

    brc_out_stage #(.OUT_REG(OUT_REG)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (vld_i),
        .hit_i   (sel_hit),
        .rsvd_i  (sel_rsvd),
        .taken_o (taken_o),
        .rsvd_o  (rsvd_o)
    );

endmodule

// File: rtl/branch_decider_chk.sv
// Checker: port-level properties of the branch evaluator, bound to the top.
// Assumes the default registered output stage for the clocked properties.
module branch_decider_chk #(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vld_i,
    input logic [DATA_W-1:0] lhs_i,
    input logic [DATA_W-1:0] rhs_i,
    input logic [2:0]        cond_i,
    input logic              taken_o,
    input logic              rsvd_o
);
    if (OUT_REG) begin : g_seq
        // R7: an idle cycle leaves both flags low at the next edge.
        assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(vld_i)) |-> (!taken_o && !rsvd_o));

        // R6: reserved code is flagged and never taken.
        assert_rsvd_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(vld_i) && ($past(cond_i[1:0]) == 2'b11))
            |-> (rsvd_o && !taken_o));

        // R6: the flag is raised only for a valid reserved code.
        assert_rsvd_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rsvd_o |-> ($past(vld_i) && ($past(cond_i[1:0]) == 2'b11)));

        // R1: equal operands under code 000 are taken.
        assert_eq_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(vld_i) && ($past(cond_i) == 3'b000)
             && ($past(lhs_i) == $past(rhs_i))) |-> taken_o);

        // R2: code 100 follows operand inequality.
        assert_ne_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(vld_i) && ($past(cond_i) == 3'b100))
            |-> (taken_o == ($past(lhs_i) != $past(rhs_i))));
    end else begin : g_comb
        // R6 and R7: combinational form of the same rules.
        always_comb begin
            if (rst_n) begin
                assert_flags_excl_R6: assert (!(taken_o && rsvd_o));
                assert_idle_comb_R7:  assert (vld_i || (!taken_o && !rsvd_o));
            end
        end
    end

endmodule

bind branch_decider branch_decider_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (vld_i),
    .lhs_i   (lhs_i),
    .rhs_i   (rhs_i),
    .cond_i  (cond_i),
    .taken_o (taken_o),
    .rsvd_o  (rsvd_o)
);

// File: tb/branch_decider_test.sv
`timescale 1ns/1ps
module branch_decider_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld_i = 1'b0;
    logic [W-1:0] lhs_i = '0;
    logic [W-1:0] rhs_i = '0;
    logic [2:0]   cond_i = 3'b000;
    logic         sign_sel_i = 1'b0;
    logic         taken_o;
    logic         rsvd_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    branch_decider #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .lhs_i(lhs_i), .rhs_i(rhs_i),
        .cond_i(cond_i), .sign_sel_i(sign_sel_i), .taken_o(taken_o), .rsvd_o(rsvd_o)
    );

    // Reference model written from the requirements.
    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [2:0] op, input logic s, input logic v,
                                  output logic tk, output logic rv);
        logic lt, eq;
        eq = (a == b);
        lt = s ? ($signed(a) < $signed(b)) : (a < b);
        tk = 1'b0;
        rv = 1'b0;
        case (op)
            3'b000: tk = eq;
            3'b100: tk = !eq;
            3'b001: tk = !lt && !eq;
            3'b010: tk = !lt;
            3'b101: tk = lt;
            3'b110: tk = lt || eq;
            default: rv = 1'b1;
        endcase
        tk = tk & v;
        rv = rv & v;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {taken,rsvd} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one input set at the falling edge, check after the next rising edge.
    task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2:0] op, input logic s, input logic v);
        logic tk, rv;
        @(negedge clk);
        lhs_i = a; rhs_i = b; cond_i = op; sign_sel_i = s; vld_i = v;
        model(a, b, op, s, v, tk, rv);
        @(posedge clk); #1;
        check(tag, {taken_o, rsvd_o}, {tk, rv});
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0; vld_i = 1'b0;
        @(posedge clk); #1;
        check("R9 reset state", {taken_o, rsvd_o}, 2'b00);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_equal;
        apply("R1 eq equal", 32'h1234_5678, 32'h1234_5678, 3'b000, 1'b0, 1'b1);
        apply("R1 eq equal signed", 32'h8000_0000, 32'h8000_0000, 3'b000, 1'b1, 1'b1);
        apply("R1 eq low-slice diff", 32'h1234_5678, 32'h1234_5679, 3'b000, 1'b0, 1'b1);
        apply("R1 eq top diff", 32'h0000_0000, 32'h8000_0000, 3'b000, 1'b1, 1'b1);
    endtask

    task automatic t_notequal;
        apply("R2 ne differ", 32'hAA00_0000, 32'h5500_0000, 3'b100, 1'b0, 1'b1);
        apply("R2 ne same", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100, 1'b1, 1'b1);
        apply("R2 ne mid slice", 32'h0001_0000, 32'h0000_0000, 3'b100, 1'b0, 1'b1);
    endtask

    task automatic t_greater;
        apply("R3 gt yes", 32'h0000_0100, 32'h0000_00FF, 3'b001, 1'b0, 1'b1);
        apply("R3 gt equal", 32'h0000_0100, 32'h0000_0100, 3'b001, 1'b0, 1'b1);
        apply("R3 ge equal", 32'h0000_0100, 32'h0000_0100, 3'b010, 1'b0, 1'b1);
        apply("R3 ge less", 32'h0000_00FF, 32'h0000_0100, 3'b010, 1'b0, 1'b1);
        apply("R3 gt upper slice wins", 32'h0100_0000, 32'h00FF_FFFF, 3'b001, 1'b0, 1'b1);
    endtask

    task automatic t_less;
        apply("R4 lt yes", 32'h0000_0001, 32'h0000_0002, 3'b101, 1'b0, 1'b1);
        apply("R4 lt equal", 32'h0000_0002, 32'h0000_0002, 3'b101, 1'b0, 1'b1);
        apply("R4 le equal", 32'h0000_0002, 32'h0000_0002, 3'b110, 1'b0, 1'b1);
        apply("R4 le greater", 32'h0000_0003, 32'h0000_0002, 3'b110, 1'b0, 1'b1);
    endtask

    task automatic t_sign;
        apply("R5 unsigned gt ffff vs 1", 32'hFFFF_FFFF, 32'h1, 3'b001, 1'b0, 1'b1);
        apply("R5 signed gt -1 vs 1", 32'hFFFF_FFFF, 32'h1, 3'b001, 1'b1, 1'b1);
        apply("R5 signed lt min vs max", 32'h8000_0000, 32'h7FFF_FFFF, 3'b101, 1'b1, 1'b1);
        apply("R5 unsigned lt min vs max", 32'h8000_0000, 32'h7FFF_FFFF, 3'b101, 1'b0, 1'b1);
        apply("R5 signed ge -2 vs -3", 32'hFFFF_FFFE, 32'hFFFF_FFFD, 3'b010, 1'b1, 1'b1);
        apply("R5 signed le -1 vs 0", 32'hFFFF_FFFF, 32'h0, 3'b110, 1'b1, 1'b1);
    endtask

    task automatic t_reserved;
        apply("R6 code 011", 32'h5, 32'h5, 3'b011, 1'b0, 1'b1);
        apply("R6 code 111", 32'h1, 32'h9, 3'b111, 1'b1, 1'b1);
        apply("R6 code 000 not reserved", 32'h1, 32'h9, 3'b000, 1'b0, 1'b1);
    endtask

    task automatic t_idle;
        apply("R7 idle taken case", 32'h7, 32'h7, 3'b000, 1'b0, 1'b0);
        apply("R7 idle reserved", 32'h7, 32'h7, 3'b111, 1'b0, 1'b0);
    endtask

    task automatic t_latency;
        apply("R8 prior idle", 32'h0, 32'h1, 3'b000, 1'b0, 1'b1);
        @(negedge clk);
        lhs_i = 32'h42; rhs_i = 32'h42; cond_i = 3'b000; vld_i = 1'b1; sign_sel_i = 1'b0;
        #1;
        check("R8 before edge holds old", {taken_o, rsvd_o}, 2'b00);
        @(posedge clk); #1;
        check("R8 after edge", {taken_o, rsvd_o}, 2'b10);
    endtask

    task automatic t_midreset;
        apply("R9 set before reset", 32'h3, 32'h3, 3'b010, 1'b0, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9 reset with valid high", {taken_o, rsvd_o}, 2'b00);
        @(negedge clk); rst_n = 1'b1; vld_i = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_equal();
        t_notequal();
        t_greater();
        t_less();
        t_sign();
        t_reserved();
        t_idle();
        t_latency();
        t_midreset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule